// File: doc/BRIEF.md
# Configuration Read/Write Completion Collector

This block collects the completion that answers a single outstanding configuration request. After the request side arms it with the access size, the low offset bits and the read/write direction, it watches a stream of completion beats. Each beat carries two 32-bit words and start/end markers. The block takes the completion status and byte count from the starting beat. It takes the returned data word from the ending beat and reports the outcome with a one-cycle `done` pulse and an error flag.

For reads, the returned word is narrowed to the requested byte or halfword and right-aligned. For writes, only the status matters and the data output stays zero. A wait strobe counts polling intervals. If the ending beat has not come by the 500th interval after arming, the request ends as a failure. Arming again at any time abandons the current request and starts a fresh wait.

Top module: `cpl_collector`

## Requirements
- R1: After reset `done` is 0 and stays 0 until a request is armed and completes.
- R2: The status is bits 15:13 of the second word (`beatWord1`) of the starting beat. A nonzero status ends the request with `doneErr`=1 and `rdData`=0.
- R3: A dword read (`reqSize`=2 or 3) with zero status returns the first word (`beatWord0`) of the ending beat on `rdData`. `done` pulses for one cycle, in the cycle after the ending beat is presented.
- R4: A byte read (`reqSize`=0) returns `(word >> 8*reqOffset) & 0xFF`.
- R5: A halfword read (`reqSize`=1) returns `(word >> 8*(reqOffset & 2)) & 0xFFFF`.
- R6: Before a starting beat has been seen, a valid beat with neither marker is ignored. After the starting beat, beats with no markers are accepted but do not change the captured status.
- R7: An ending beat that arrives with no starting beat since arming ends the request as a failure.
- R8: For a write request (`reqWrite`=1), `rdData` is 0 on completion. `doneErr` reflects the status alone.
- R9: If 500 `waitTick` pulses pass after arming without an ending beat, the request ends with `doneErr`=1. An ending beat in the same cycle as the 500th pulse, or earlier, completes normally.
- R10: Asserting `reqArm` restarts the interval count and drops any partially received completion.
- R11: Beats presented while no request is armed produce no `done`.
- R12: `cplBytes` holds bits 11:0 of the starting beat's second word. It is 0 after arming until a starting beat is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqArm | input | 1 | Start waiting for a new completion |
| reqWrite | input | 1 | Armed request is a write |
| reqOffset | input | 2 | Low two bits of the register offset |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 or 3 dword |
| beatValid | input | 1 | A completion beat is presented |
| beatSop | input | 1 | Beat starts the completion |
| beatEop | input | 1 | Beat ends the completion |
| beatWord0 | input | 32 | First word of the beat |
| beatWord1 | input | 32 | Second word of the beat |
| waitTick | input | 1 | One polling interval has elapsed |
| done | output | 1 | One-cycle completion pulse |
| doneErr | output | 1 | Request failed (valid with done) |
| rdData | output | 32 | Extracted read data (valid with done) |
| cplBytes | output | 12 | Byte count from the starting beat |

## Verification
The hardest situation to reach is the timeout boundary. The ending beat has to arrive exactly in the cycle of the 500th wait pulse, or just before it, and a re-arm has to land partway through a long wait. The stimulus drives long runs of back-to-back `waitTick` pulses with counted lengths. It places the ending beat on the same cycle as the final pulse, and it re-arms after 300 pulses and then supplies another 300. A behavioural model advanced on every clock predicts each `done`, error flag and data value.

// File: rtl/cplrx_pkg.sv
package cplrx_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xferSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic arm;      // new request latched
    logic capHdr;   // starting beat accepted this cycle
    logic finish;   // ending beat accepted this cycle
    logic expire;   // wait limit reached without ending beat
  } ctrlStrb_t;
endpackage

// File: rtl/cplrx_ctrl.sv
module cplrx_ctrl
  import cplrx_pkg::*;
#(
  parameter int WAIT_LIMIT = 500,
  localparam int CNT_W = $clog2(WAIT_LIMIT + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqArm,
  input  logic      beatValid,
  input  logic      beatSop,
  input  logic      beatEop,
  input  logic      waitTick,
  output ctrlStrb_t strb
);
  typedef enum logic {ST_IDLE, ST_WAIT} ctrlState_e;

  ctrlState_e       state;
  logic             sopSeen;
  logic [CNT_W-1:0] waitCnt;
  logic             accept;

  always_comb begin
    strb   = '0;
    accept = 1'b0;
    strb.arm = reqArm;
    if (state == ST_WAIT && !reqArm) begin
      accept      = beatValid && (beatSop || beatEop || sopSeen);
      strb.capHdr = accept && beatSop;
      strb.finish = accept && beatEop;
      strb.expire = !strb.finish && waitTick &&
                    (waitCnt == CNT_W'(WAIT_LIMIT - 1));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sopSeen <= 1'b0;
      waitCnt <= '0;
    end else if (strb.arm) begin
      state   <= ST_WAIT;
      sopSeen <= 1'b0;
      waitCnt <= '0;
    end else if (state == ST_WAIT) begin
      if (strb.capHdr) sopSeen <= 1'b1;
      if (strb.finish || strb.expire) begin
        state <= ST_IDLE;
      end else if (waitTick) begin
        waitCnt <= waitCnt + 1'b1;
      end
    end
  end

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt < CNT_W'(WAIT_LIMIT));

  // R9
  end_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.finish && strb.expire));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !(strb.finish || strb.expire || strb.capHdr));
endmodule

// File: rtl/cplrx_datapath.sv
module cplrx_datapath
  import cplrx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int STAT_LSB = 13,
  parameter int STAT_W  = 3,
  parameter int BC_W    = 12,
  localparam int OFF_W  = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              reqWrite,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] beatWord0,
  input  logic [DATA_W-1:0] beatWord1,
  output logic              done,
  output logic              doneErr,
  output logic [DATA_W-1:0] rdData,
  output logic [BC_W-1:0]   cplBytes
);
  logic [STAT_W-1:0] statusReg;
  logic [STAT_W-1:0] effStatus;
  logic [OFF_W-1:0]  offReg;
  logic [1:0]        sizeReg;
  logic              wrReg;
  logic [OFF_W+2:0]  shiftAmt;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] narrowed;
  logic              effErr;

  assign effStatus = strb.capHdr ? beatWord1[STAT_LSB +: STAT_W] : statusReg;
  assign effErr    = (effStatus != '0);

  always_comb begin
    shiftAmt = '0;
    if (sizeReg == SZ_BYTE) shiftAmt = {offReg, 3'b000};
    else if (sizeReg == SZ_HALF) shiftAmt = {offReg[OFF_W-1], {(OFF_W-1){1'b0}}, 3'b000};
    shifted = beatWord0 >> shiftAmt;
    case (sizeReg)
      SZ_BYTE: narrowed = shifted & DATA_W'(8'hFF);
      SZ_HALF: narrowed = shifted & DATA_W'(16'hFFFF);
      default: narrowed = beatWord0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= '0;
      offReg    <= '0;
      sizeReg   <= '0;
      wrReg     <= 1'b0;
      cplBytes  <= '0;
      done      <= 1'b0;
      doneErr   <= 1'b0;
      rdData    <= '0;
    end else begin
      done <= strb.finish || strb.expire;
      if (strb.arm) begin
        statusReg <= STAT_W'(1);
        cplBytes  <= '0;
        offReg    <= reqOffset;
        sizeReg   <= reqSize;
        wrReg     <= reqWrite;
      end else if (strb.capHdr) begin
        statusReg <= beatWord1[STAT_LSB +: STAT_W];
        cplBytes  <= beatWord1[BC_W-1:0];
      end
      if (strb.finish) begin
        doneErr <= effErr;
        rdData  <= (effErr || wrReg) ? '0 : narrowed;
      end else if (strb.expire) begin
        doneErr <= 1'b1;
        rdData  <= '0;
      end
    end
  end

  // R2
  err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && doneErr) |-> (rdData == '0));

  // R4
  byte_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && sizeReg == SZ_BYTE) |-> ((rdData >> 8) == '0));

  // R5
  half_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && sizeReg == SZ_HALF) |-> ((rdData >> 16) == '0));

  // R8
  write_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && wrReg) |-> (rdData == '0));
endmodule

// File: rtl/cpl_collector.sv
module cpl_collector
  import cplrx_pkg::*;
#(
  parameter int WAIT_LIMIT = 500
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqArm,
  input  logic        reqWrite,
  input  logic [1:0]  reqOffset,
  input  logic [1:0]  reqSize,
  input  logic        beatValid,
  input  logic        beatSop,
  input  logic        beatEop,
  input  logic [31:0] beatWord0,
  input  logic [31:0] beatWord1,
  input  logic        waitTick,
  output logic        done,
  output logic        doneErr,
  output logic [31:0] rdData,
  output logic [11:0] cplBytes
);
  ctrlStrb_t strb;

  cplrx_ctrl #(.WAIT_LIMIT(WAIT_LIMIT)) uCtrl (
    .clk(clk), .rstN(rstN), .reqArm(reqArm), .beatValid(beatValid),
    .beatSop(beatSop), .beatEop(beatEop), .waitTick(waitTick), .strb(strb)
  );

  cplrx_datapath #(.DATA_W(32), .STAT_LSB(13), .STAT_W(3), .BC_W(12)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .reqSize(reqSize), .beatWord0(beatWord0),
    .beatWord1(beatWord1), .done(done), .doneErr(doneErr),
    .rdData(rdData), .cplBytes(cplBytes)
  );

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !$past(reqArm)) |=> !done);
endmodule

// File: tb/sim_cpl_collector.sv
module sim_cpl_collector;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqArm = 0, reqWrite = 0, beatValid = 0, beatSop = 0, beatEop = 0, waitTick = 0;
  logic [1:0]  reqOffset = 0, reqSize = 0;
  logic [31:0] beatWord0 = 0, beatWord1 = 0;
  logic        done, doneErr;
  logic [31:0] rdData;
  logic [11:0] cplBytes;

  int errs = 0, checks = 0, cycles = 0;
  string curReq = "R1";

  always #10 clk = ~clk;

  cpl_collector u0 (
    .clk(clk), .rstN(rstN), .reqArm(reqArm), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .reqSize(reqSize), .beatValid(beatValid),
    .beatSop(beatSop), .beatEop(beatEop), .beatWord0(beatWord0),
    .beatWord1(beatWord1), .waitTick(waitTick), .done(done),
    .doneErr(doneErr), .rdData(rdData), .cplBytes(cplBytes)
  );

  // Behavioural reference model
  bit mActive, mSop, mWr, eDone, eErr;
  int mStat, mCnt, mOff, mSize;
  longint unsigned eData, eBytes;

  function automatic longint unsigned pick(longint unsigned w, int off, int sz);
    if (sz == 0) return (w >> (8 * off)) & 64'hFF;
    if (sz == 1) return (w >> (8 * (off & 2))) & 64'hFFFF;
    return w;
  endfunction

  always @(posedge clk) begin
    eDone = 0;
    if (!rstN) begin
      mActive = 0; mSop = 0; mStat = 0; mCnt = 0; eBytes = 0;
    end else if (reqArm) begin
      mActive = 1; mSop = 0; mStat = 1; mCnt = 0; eBytes = 0;
      mWr = reqWrite; mOff = reqOffset; mSize = reqSize;
    end else if (mActive) begin
      if (beatValid && (beatSop || beatEop || mSop)) begin
        if (beatSop) begin
          mSop = 1; mStat = (beatWord1 >> 13) % 8; eBytes = beatWord1 % 4096;
        end
        if (beatEop) begin
          eDone = 1; eErr = (mStat != 0);
          eData = (eErr || mWr) ? 0 : pick(beatWord0, mOff, mSize);
          mActive = 0;
        end
      end
      if (mActive && waitTick) begin
        mCnt++;
        if (mCnt == 500) begin
          eDone = 1; eErr = 1; eData = 0; mActive = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      checks++;
      if (done !== eDone) begin
        errs++; $display("FAIL %s done=%0b expected %0b", curReq, done, eDone);
      end else if (eDone) begin
        checks++;
        if (doneErr !== eErr || rdData !== 32'(eData) || cplBytes !== 12'(eBytes)) begin
          errs++;
          $display("FAIL %s err/data/bytes=%0b/%h/%h expected %0b/%h/%h",
                   curReq, doneErr, rdData, cplBytes, eErr, 32'(eData), 12'(eBytes));
        end
      end
    end
    if (cycles > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  function automatic logic [31:0] mkW1(int stat, int bc);
    return {16'h0, 3'(stat), 1'b0, 12'(bc)};
  endfunction

  task automatic arm(bit wr, int off, int sz);
    @(negedge clk);
    reqArm = 1; reqWrite = wr; reqOffset = 2'(off); reqSize = 2'(sz);
    @(negedge clk);
    reqArm = 0;
  endtask

  task automatic beat(bit s, bit e, logic [31:0] w0, logic [31:0] w1, bit tk = 0);
    beatValid = 1; beatSop = s; beatEop = e; beatWord0 = w0; beatWord1 = w1; waitTick = tk;
    @(negedge clk);
    beatValid = 0; beatSop = 0; beatEop = 0; waitTick = 0;
  endtask

  task automatic ticks(int n);
    waitTick = 1;
    repeat (n) @(negedge clk);
    waitTick = 0;
  endtask

  task automatic readOne(int off, int sz, logic [31:0] data);
    arm(0, off, sz);
    beat(1, 0, 32'h0, mkW1(0, 4));
    beat(0, 1, data, 32'h0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 1'b0) begin errs++; $display("FAIL R1 done=%0b expected 0", done); end
    rstN = 1;
    repeat (2) @(negedge clk);

    curReq = "R3"; readOne(0, 2, 32'hDEAD_BEEF);
    curReq = "R3"; readOne(1, 3, 32'h1234_5678);
    curReq = "R4";
    for (int o = 0; o < 4; o++) readOne(o, 0, 32'hA1B2_C3D4);
    curReq = "R5";
    for (int o = 0; o < 4; o++) readOne(o, 1, 32'h5566_7788);

    curReq = "R2";
    arm(0, 0, 2); beat(1, 0, 0, mkW1(2, 4)); beat(0, 1, 32'hFFFF_FFFF, 0); @(negedge clk);
    arm(0, 0, 2); beat(1, 1, 32'h1111_2222, mkW1(7, 4)); @(negedge clk);

    curReq = "R6";
    arm(0, 2, 0);
    beat(0, 0, 0, mkW1(5, 9));
    beat(1, 0, 0, mkW1(0, 4));
    beat(0, 0, 32'h9999_9999, mkW1(6, 1));
    beat(0, 1, 32'h00AB_0000, 0);
    @(negedge clk);

    curReq = "R7";
    arm(0, 0, 2); beat(0, 1, 32'hCAFE_F00D, mkW1(0, 4)); @(negedge clk);

    curReq = "R8";
    arm(1, 0, 2); beat(1, 0, 0, mkW1(0, 0)); beat(0, 1, 32'h7777_7777, 0); @(negedge clk);
    arm(1, 0, 2); beat(1, 1, 32'h7777_7777, mkW1(4, 0)); @(negedge clk);

    curReq = "R9";
    arm(0, 0, 2); ticks(505); @(negedge clk);
    arm(0, 0, 2); beat(1, 0, 0, mkW1(0, 4)); ticks(499);
    beat(0, 1, 32'h0BAD_CAFE, 0, 1); @(negedge clk);
    arm(0, 0, 2); ticks(499); @(negedge clk);
    beat(1, 1, 32'h4444_3333, mkW1(0, 4)); @(negedge clk);

    curReq = "R10";
    arm(0, 0, 2); beat(1, 0, 0, mkW1(3, 8)); ticks(300);
    arm(0, 3, 0); ticks(300);
    beat(0, 1, 32'hFF00_0000, 0);
    @(negedge clk);
    arm(0, 3, 0); ticks(300); beat(1, 0, 0, mkW1(0, 4)); ticks(300);
    beat(0, 1, 32'hFF00_0000, 0);
    @(negedge clk);

    curReq = "R11";
    beat(1, 1, 32'h1, mkW1(0, 4));
    beat(0, 1, 32'h2, 0);
    repeat (3) @(negedge clk);

    curReq = "R12";
    arm(0, 0, 2); beat(1, 0, 0, mkW1(0, 12'hABC)); beat(0, 1, 32'h55, 0); @(negedge clk);
    arm(0, 0, 2); ticks(500); @(negedge clk);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule